// File: doc/BRIEF.md
# Consumer-IR FIFO and Interrupt Status Controller

This block sits between a consumer-IR receive/transmit path and host software. Received symbol bytes go into a receive queue that the host drains through a register port. Bytes the host writes into a transmit queue are pulled out one at a time by the pulse encoder. Both queues have a programmable trigger level.

Eight sticky status flags record what happened. Queue events set them: data arriving, a trigger level crossed, overrun, draining to empty, and underrun. So do two pulses from the receive path: end of packet and minimum length seen. Each flag has a matching enable bit. One interrupt line is raised while any enabled flag is set. Software clears a flag by writing 1 to its position.

The register port is a plain read/write strobe interface with a 3-bit address. Reads are combinational. A read strobe at the receive-data address removes the head byte at the next clock edge.

Top module: `cir_irq_ctrl`

## Requirements
- R1: A synchronous reset empties both queues, clears all status and enable bits, and sets both trigger levels to half the queue depth (16 for depth 32).
- R2: Register addresses: 0 status, 1 enable, 2 receive data (a read with the read strobe pops one byte), 3 transmit data (a write pushes one byte), 4 receive trigger level, 5 transmit trigger level, 6 receive count, 7 transmit count. The receive queue returns bytes in arrival order.
- R3: Status bit 7 (data ready) sets when a received byte is accepted. It clears when a read empties the receive queue, or when software clears it.
- R4: Status bit 6 sets on the edge where the receive count rises to or above the receive trigger level.
- R5: A byte arriving at a full receive queue is dropped. The stored bytes and the count stay as they were, and status bits 4 (overrun) and 7 are both set.
- R6: The transmit queue hands bytes to the encoder in write order. Status bit 2 sets when the transmit count falls to or below its trigger level. Status bit 3 sets when the count falls to zero.
- R7: A transmit pop request while the queue is empty sets status bit 1 (underrun) and leaves the count at zero.
- R8: The packet-end pulse sets status bit 5. The minimum-length pulse sets status bit 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: When a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.
- R11: The interrupt output is high exactly when the bitwise AND of status and enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops at address 2) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| rxPushValid | input | 1 | Receive byte valid from the receive path |
| rxPushData | input | 8 | Receive byte |
| pktEndPulse | input | 1 | Packet-end event |
| minLenPulse | input | 1 | Minimum-length event |
| txPopReq | input | 1 | Encoder requests the next transmit byte |
| txPopData | output | 8 | Head of the transmit queue |
| irq | output | 1 | Interrupt request |

## Verification
Every status change is computed from the counts before and after the current edge. A set or clear is therefore visible at the first rising edge that samples the causing strobe. The interrupt line follows in the same cycle, because it is a pure function of the status and enable registers. Read data and the transmit head are combinational, so the bench samples them before the edge that pops them. The bench drives stimulus on the falling edge and checks status one time unit after the next rising edge, which matches the single register stage on every path.

// File: rtl/cir_irq_pkg.sv
package cir_irq_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_ENABLE = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_RXDATA = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_TXDATA = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_RXLVL  = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_TXLVL  = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_RXCNT  = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_TXCNT  = 3'd7;

  // status bit positions; host software decodes these
  localparam int ST_RDY    = 7;
  localparam int ST_RTRIG  = 6;
  localparam int ST_PKTEND = 5;
  localparam int ST_OVR    = 4;
  localparam int ST_TEMPTY = 3;
  localparam int ST_TTRIG  = 2;
  localparam int ST_UNDR   = 1;
  localparam int ST_MINLEN = 0;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
    logic enWr;
    logic rxLvlWr;
    logic txLvlWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/cir_byte_fifo.sv
module cir_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R7: the controller never pops an empty queue
  a_r7_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

  // R5: the controller never pushes a full queue
  a_r5_no_full_push: assert property (@(posedge clk) disable iff (rst)
    push |-> count != CNT_W'(DEPTH));

endmodule

// File: rtl/cir_irq_datapath.sv
module cir_irq_datapath
  import cir_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       stb,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  input  logic [7:0]         rxPushData,
  input  logic [7:0]         statusQ,
  output logic [7:0]         regRdData,
  output logic [7:0]         txPopData,
  output logic [CNT_W-1:0]   rxCount,
  output logic [CNT_W-1:0]   txCount,
  output logic [7:0]         rxLevel,
  output logic [7:0]         txLevel,
  output logic [7:0]         enableQ
);

  localparam logic [7:0] LEVEL_RST = 8'(DEPTH / 2);

  logic [7:0] rxHead;

  cir_byte_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk      (clk),
    .rst      (rst),
    .push     (stb.rxPush),
    .pushData (rxPushData),
    .pop      (stb.rxPop),
    .headData (rxHead),
    .count    (rxCount)
  );

  cir_byte_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_txFifo (
    .clk      (clk),
    .rst      (rst),
    .push     (stb.txPush),
    .pushData (regWrData),
    .pop      (stb.txPop),
    .headData (txPopData),
    .count    (txCount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= '0;
      rxLevel <= LEVEL_RST;
      txLevel <= LEVEL_RST;
    end else begin
      if (stb.enWr)    enableQ <= regWrData;
      if (stb.rxLvlWr) rxLevel <= regWrData;
      if (stb.txLvlWr) txLevel <= regWrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: regRdData = statusQ;
      ADDR_ENABLE: regRdData = enableQ;
      ADDR_RXDATA: regRdData = rxHead;
      ADDR_TXDATA: regRdData = 8'h00;
      ADDR_RXLVL:  regRdData = rxLevel;
      ADDR_TXLVL:  regRdData = txLevel;
      ADDR_RXCNT:  regRdData = 8'(rxCount);
      ADDR_TXCNT:  regRdData = 8'(txCount);
      default:     regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/cir_irq_control.sv
module cir_irq_control
  import cir_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  input  logic               rxPushValid,
  input  logic               pktEndPulse,
  input  logic               minLenPulse,
  input  logic               txPopReq,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [7:0]         rxLevel,
  input  logic [7:0]         txLevel,
  input  logic [7:0]         enableQ,
  output ctrlStrobes_t       stb,
  output logic [7:0]         statusQ,
  output logic               irq
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic rxFull, rxEmpty, txFull, txEmpty;
  logic rxOverrun, txUnderrun;
  logic [CNT_W-1:0] rxCountNext, txCountNext;
  logic rxTrigNow, rxTrigNext, txTrigNow, txTrigNext;
  logic [7:0] setMask, clrMask, statusNext;

  assign rxFull  = (rxCount == FULL);
  assign rxEmpty = (rxCount == '0);
  assign txFull  = (txCount == FULL);
  assign txEmpty = (txCount == '0);

  // host-side decode and queue gating
  always_comb begin
    stb.rxPush  = rxPushValid && !rxFull;
    stb.rxPop   = regRdEn && (regAddr == ADDR_RXDATA) && !rxEmpty;
    stb.txPush  = regWrEn && (regAddr == ADDR_TXDATA) && !txFull;
    stb.txPop   = txPopReq && !txEmpty;
    stb.enWr    = regWrEn && (regAddr == ADDR_ENABLE);
    stb.rxLvlWr = regWrEn && (regAddr == ADDR_RXLVL);
    stb.txLvlWr = regWrEn && (regAddr == ADDR_TXLVL);
  end

  assign rxOverrun  = rxPushValid && rxFull;
  assign txUnderrun = txPopReq && txEmpty;

  assign rxCountNext = rxCount + CNT_W'(stb.rxPush) - CNT_W'(stb.rxPop);
  assign txCountNext = txCount + CNT_W'(stb.txPush) - CNT_W'(stb.txPop);

  assign rxTrigNow  = 8'(rxCount)     >= rxLevel;
  assign rxTrigNext = 8'(rxCountNext) >= rxLevel;
  assign txTrigNow  = 8'(txCount)     <= txLevel;
  assign txTrigNext = 8'(txCountNext) <= txLevel;

  always_comb begin
    setMask = '0;
    setMask[ST_RDY]    = stb.rxPush || rxOverrun;
    setMask[ST_RTRIG]  = rxTrigNext && !rxTrigNow;
    setMask[ST_PKTEND] = pktEndPulse;
    setMask[ST_OVR]    = rxOverrun;
    setMask[ST_TEMPTY] = (txCountNext == '0) && !txEmpty;
    setMask[ST_TTRIG]  = txTrigNext && !txTrigNow;
    setMask[ST_UNDR]   = txUnderrun;
    setMask[ST_MINLEN] = minLenPulse;

    clrMask = (regWrEn && regAddr == ADDR_STATUS) ? regWrData : 8'h00;
    if (rxCountNext == '0 && !rxEmpty) clrMask[ST_RDY] = 1'b1;

    // hardware events take priority over clears
    statusNext = (statusQ & ~clrMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= statusNext;
  end

  assign irq = |(statusQ & enableQ);

  // R5: overrun flags both overrun and data ready, count held
  a_r5_overrun_flags: assert property (@(posedge clk) disable iff (rst)
    (rxPushValid && rxFull) |=> (statusQ[ST_OVR] && statusQ[ST_RDY]));

  a_r5_full_held: assert property (@(posedge clk) disable iff (rst)
    (rxPushValid && rxFull && !(regRdEn && regAddr == ADDR_RXDATA)) |=> rxFull);

  // R7: underrun is flagged
  a_r7_underrun_flag: assert property (@(posedge clk) disable iff (rst)
    (txPopReq && txEmpty) |=> (statusQ[ST_UNDR] && txEmpty));

  // R10: an event pulse wins against a same-cycle clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    pktEndPulse |=> statusQ[ST_PKTEND]);

  // R4: trigger flag only rises when the level is met
  a_r4_trig_level: assert property (@(posedge clk) disable iff (rst)
    $rose(statusQ[ST_RTRIG]) |-> (8'(rxCount) >= rxLevel));

  // R11: no interrupt without an enable
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> (enableQ != 8'h00 && statusQ != 8'h00));

  // R1: reset leaves status clear
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (statusQ == 8'h00));

endmodule

// File: rtl/cir_irq_ctrl.sv
module cir_irq_ctrl
  import cir_irq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        rxPushValid,
  input  logic [7:0]  rxPushData,
  input  logic        pktEndPulse,
  input  logic        minLenPulse,
  input  logic        txPopReq,
  output logic [7:0]  txPopData,
  output logic        irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrobes_t     stb;
  logic [7:0]       statusQ, enableQ, rxLevel, txLevel;
  logic [CNT_W-1:0] rxCount, txCount;

  cir_irq_control #(.DEPTH(DEPTH)) u_control (
    .clk         (clk),
    .rst         (rst),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .rxPushValid (rxPushValid),
    .pktEndPulse (pktEndPulse),
    .minLenPulse (minLenPulse),
    .txPopReq    (txPopReq),
    .rxCount     (rxCount),
    .txCount     (txCount),
    .rxLevel     (rxLevel),
    .txLevel     (txLevel),
    .enableQ     (enableQ),
    .stb         (stb),
    .statusQ     (statusQ),
    .irq         (irq)
  );

  cir_irq_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .rxPushData (rxPushData),
    .statusQ    (statusQ),
    .regRdData  (regRdData),
    .txPopData  (txPopData),
    .rxCount    (rxCount),
    .txCount    (txCount),
    .rxLevel    (rxLevel),
    .txLevel    (txLevel),
    .enableQ    (enableQ)
  );

endmodule

// File: tb/cir_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cir_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       rxPushValid = 1'b0;
  logic [7:0] rxPushData = '0;
  logic       pktEndPulse = 1'b0, minLenPulse = 1'b0;
  logic       txPopReq = 1'b0;
  logic [7:0] txPopData;
  logic       irq;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cir_irq_ctrl u_cir_irq_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic popRx(output logic [7:0] d);
    @(negedge clk);
    regAddr = 3'd2; regRdEn = 1'b1;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    @(negedge clk);
    rxPushData = d; rxPushValid = 1'b1;
    tick();
    rxPushValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    peek(3'd0, d); chk("R1 status", d, 8'h00);
    peek(3'd1, d); chk("R1 enable", d, 8'h00);
    peek(3'd6, d); chk("R1 rxCount", d, 8'd0);
    peek(3'd7, d); chk("R1 txCount", d, 8'd0);
    peek(3'd4, d); chk("R1 rxLevel", d, 8'd16);
    peek(3'd5, d); chk("R1 txLevel", d, 8'd16);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic testSingleRx();
    logic [7:0] d;
    pushRx(8'h5A);
    peek(3'd0, d); chk("R3 ready set", d, 8'h80);
    peek(3'd6, d); chk("R2 rxCount one", d, 8'd1);
    popRx(d);      chk("R2 rx data", d, 8'h5A);
    peek(3'd0, d); chk("R3 ready auto-clear", d, 8'h00);
    peek(3'd6, d); chk("R2 rxCount zero", d, 8'd0);
  endtask

  task automatic testRxTrigOverrun();
    logic [7:0] d;
    writeReg(3'd4, 8'd4);
    for (int i = 0; i < 3; i++) pushRx(8'h10 + 8'(i));
    peek(3'd0, d); chk("R4 below level", d[6], 1'b0);
    pushRx(8'h13);
    peek(3'd0, d); chk("R4 level reached", d[6], 1'b1);
    writeReg(3'd0, 8'h40);
    peek(3'd0, d); chk("R9 clear bit6 only", d, 8'h80);
    for (int i = 4; i < 32; i++) pushRx(8'h10 + 8'(i));
    writeReg(3'd0, 8'h80);
    peek(3'd0, d); chk("R9 clear ready", d[7], 1'b0);
    pushRx(8'hEE);
    peek(3'd0, d); chk("R5 overrun and ready", {d[7], d[4]}, 2'b11);
    peek(3'd6, d); chk("R5 count held", d, 8'd32);
    for (int i = 0; i < 32; i++) begin
      popRx(d);
      chk("R5/R2 data kept in order", d, 8'h10 + 8'(i));
    end
    peek(3'd0, d); chk("R3 ready clears on empty", d[7], 1'b0);
    writeReg(3'd0, 8'hFF);
  endtask

  task automatic testTx();
    logic [7:0] d;
    writeReg(3'd5, 8'd2);
    for (int i = 0; i < 5; i++) writeReg(3'd3, 8'hA0 + 8'(i));
    peek(3'd7, d); chk("R6 txCount", d, 8'd5);
    peek(3'd0, d); chk("R6 no flags on fill", d, 8'h00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 chk("R6 tx order", txPopData, 8'hA0 + 8'(i));
      txPopReq = 1'b1;
      tick();
      txPopReq = 1'b0;
      if (i == 1) begin peek(3'd0, d); chk("R6 trig not yet", d[2], 1'b0); end
      if (i == 2) begin peek(3'd0, d); chk("R6 trig at level", d[2], 1'b1); end
      if (i == 3) begin peek(3'd0, d); chk("R6 not empty yet", d[3], 1'b0); end
    end
    peek(3'd0, d); chk("R6 empty flag", d[3], 1'b1);
    chk("R7 no underrun yet", d[1], 1'b0);
    @(negedge clk); txPopReq = 1'b1; tick(); txPopReq = 1'b0;
    peek(3'd0, d); chk("R7 underrun flag", d[1], 1'b1);
    peek(3'd7, d); chk("R7 count stays zero", d, 8'd0);
    writeReg(3'd0, 8'hFF);
  endtask

  task automatic testEventsIrq();
    logic [7:0] d;
    @(negedge clk); pktEndPulse = 1'b1; tick(); pktEndPulse = 1'b0;
    @(negedge clk); minLenPulse = 1'b1; tick(); minLenPulse = 1'b0;
    peek(3'd0, d); chk("R8 pkt end and min len", d, 8'h21);
    chk("R11 irq low when disabled", irq, 1'b0);
    writeReg(3'd1, 8'h20);
    chk("R11 irq on enabled bit", irq, 1'b1);
    writeReg(3'd0, 8'h00);
    peek(3'd0, d); chk("R9 zero write no effect", d, 8'h21);
    writeReg(3'd0, 8'h20);
    peek(3'd0, d); chk("R9 w1c bit5", d, 8'h01);
    chk("R11 irq drops", irq, 1'b0);
    @(negedge clk);
    regAddr = 3'd0; regWrData = 8'h20; regWrEn = 1'b1; pktEndPulse = 1'b1;
    tick();
    regWrEn = 1'b0; pktEndPulse = 1'b0;
    peek(3'd0, d); chk("R10 set wins", d[5], 1'b1);
    chk("R11 irq from set bit", irq, 1'b1);
  endtask

  task automatic testMidReset();
    logic [7:0] d;
    pushRx(8'h33);
    writeReg(3'd3, 8'h44);
    doReset();
    peek(3'd0, d); chk("R1 status after reset", d, 8'h00);
    peek(3'd1, d); chk("R1 enable after reset", d, 8'h00);
    peek(3'd6, d); chk("R1 rx empty after reset", d, 8'd0);
    peek(3'd7, d); chk("R1 tx empty after reset", d, 8'd0);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  initial begin
    doReset();
    testReset();
    testSingleRx();
    testRxTrigOverrun();
    testTx();
    testEventsIrq();
    testMidReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule